// File: doc/BRIEF.md
# Zero-Clear Single-Port RAM Wrapper

This block wraps a single-port word memory so that the whole memory can be made to read as zero in one clock cycle. It does this without clearing the storage array. Each word has one flag flip-flop next to it. The flag is 1 when the word has been written since the last clear. The clear input only drops these flags. Stored words whose flag is 0 are replaced by zero on the read port. The array itself stays a plain behavioural memory with no reset, so a synthesis tool can map it onto block RAM.

A single address port serves both reads and writes. A read is requested with the read enable. The result appears on the registered read-data output one clock later and stays there until the next read. The clear can be pulsed in any cycle, including back to back. The memory is ready for use in the very next cycle, with no wait time.

Top module: `zclr_ram`

## Requirements
- R1: The synchronous active-high reset sets the read-data output to zero and drops every word flag. After reset, every address reads zero until it is written.
- R2: A read of a word not written since the last clear or reset returns all zeros. The result appears one clock after the cycle in which the read enable is high.
- R3: A write stores the data and sets that word's flag. A later read of that address returns the written data one clock after the read enable.
- R4: One cycle of clear makes every word read zero afterwards, whatever it held before. A word written after the clear returns its new data, while the other words stay zero.
- R5: When clear and write enable are high in the same cycle, the clear wins. The written word reads zero afterwards.
- R6: A read and a write in the same cycle (same address) return the word as it was before the write, masked by its flag before the write. A following read returns the new data.
- R7: While the read enable is low, the read-data output keeps its value, even across writes and clears.
- R8: Clear needs no recovery time. A read in the cycle right after a clear returns zero. A write in the cycle right after a clear is kept and read back correctly. Consecutive clear cycles are allowed.
- R9: A read issued in the same cycle as a clear returns the word as it stood before the clear. The next read of that word returns zero.
- R10: Writing the same address twice leaves the later data in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | One-cycle clear of all word flags |
| wr_en | input | 1 | Write enable for the word at `addr` |
| rd_en | input | 1 | Read request for the word at `addr` |
| addr | input | AW (8 by default) | Shared read/write word address |
| wr_data | input | WIDTH (32 by default) | Data to store |
| rd_data | output | WIDTH (32 by default) | Registered read result, zero for unwritten words |

## Verification
The bench builds the wrapper with a depth of 16 words and a width of 16 bits. With this size, every flag can be set, cleared and read back in a full sweep of the address space within a few hundred cycles. The narrower word still carries distinct patterns for each address. It also covers the all-ones and near-zero values, so a masked zero cannot be mistaken for stored data. The same-cycle cases are each driven as a single cycle of the shared address port: clear with write, clear with read, and read with write.

// File: rtl/zclr_pkg.sv
package zclr_pkg;

  // Address width for a word count; at least one bit.
  function automatic int unsigned addr_bits(input int unsigned words);
    return (words <= 2) ? 1 : $clog2(words);
  endfunction

endpackage

// File: rtl/zclr_flags.sv
// One written-since-clear flag per word, kept in flip-flops so a
// clear can drop all of them in a single cycle.
module zclr_flags #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  output logic          hit
);

  logic [DEPTH-1:0] flag;

  for (genvar g = 0; g < DEPTH; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || clr)
        flag[g] <= 1'b0;
      else if (wr_en && (addr == AW'(g)))
        flag[g] <= 1'b1;
    end
  end

  // Pre-edge flag of the addressed word; the store samples it with the data.
  assign hit = flag[addr];

  p_clear_empties_r4: assert property (@(posedge clk) disable iff (rst)
    clr |=> (flag == '0));

  p_write_marks_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clr) |=> flag[$past(addr)]);

  p_clear_beats_write_r5: assert property (@(posedge clk) disable iff (rst)
    (clr && wr_en) |=> !flag[$past(addr)]);

endmodule

// File: rtl/zclr_store.sv
// Behavioural word array with no reset, plus a registered read port whose
// synchronous zeroing is driven by the word flag (maps to a RAM output
// register with sync reset).
module zclr_store #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             hit,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_q
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[addr] <= wr_data;
  end

  // Read-first: the nonblocking write above lands after this read samples.
  always_ff @(posedge clk) begin
    if (rst)
      rd_q <= '0;
    else if (rd_en) begin
      if (!hit)
        rd_q <= '0;
      else
        rd_q <= mem[addr];
    end
  end

  p_idle_holds_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_q));

  p_unwritten_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !hit) |=> (rd_q == '0));

endmodule

// File: rtl/zclr_ram.sv
module zclr_ram #(
  parameter  int unsigned WIDTH = 32,
  parameter  int unsigned DEPTH = 256,
  localparam int unsigned AW    = zclr_pkg::addr_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data
);

  logic hit;

  zclr_flags #(.DEPTH(DEPTH), .AW(AW)) i_flags (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .wr_en (wr_en),
    .addr  (addr),
    .hit   (hit)
  );

  zclr_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) i_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .hit     (hit),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_q    (rd_data)
  );

endmodule

// File: tb/test_zclr_ram.sv
`timescale 1ns/1ps
module test_zclr_ram;

  localparam int unsigned W  = 16;
  localparam int unsigned D  = 16;
  localparam int unsigned AW = zclr_pkg::addr_bits(D);

  logic          clk = 1'b0;
  logic          rst, clr, wr_en, rd_en;
  logic [AW-1:0] addr;
  logic [W-1:0]  wr_data, rd_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [W-1:0] m [D];
  logic         v [D];

  always #10 clk = ~clk;

  zclr_ram #(.WIDTH(W), .DEPTH(D)) i_zclr_ram (
    .clk(clk), .rst(rst), .clr(clr), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data=%h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge; return at the next falling edge.
  task automatic step(input logic c, input logic w, input int a,
                      input logic [W-1:0] d, input logic r);
    clr = c; wr_en = w; addr = AW'(a); wr_data = d; rd_en = r;
    @(negedge clk);
    clr = 0; wr_en = 0; rd_en = 0;
  endtask

  task automatic model_clear();
    for (int i = 0; i < D; i++) v[i] = 1'b0;
  endtask

  task automatic wr(input int a, input logic [W-1:0] d);
    step(0, 1, a, d, 0);
    m[a] = d; v[a] = 1'b1;
  endtask

  task automatic rd(input int a, input string req);
    logic [W-1:0] exp;
    exp = v[a] ? m[a] : '0;
    step(0, 0, a, '0, 1);
    chk(req, rd_data, exp);
  endtask

  task automatic t_reset();
    chk("R1", rd_data, '0);
    for (int a = 0; a < D; a++) rd(a, "R1");
    wr(1, 16'hBEEF);
    rd(1, "R3");
    rst = 1; step(0, 0, 0, '0, 0); step(0, 0, 0, '0, 0); rst = 0;
    model_clear();
    chk("R1", rd_data, '0);
    rd(1, "R1");
  endtask

  task automatic t_write_read();
    for (int a = 0; a < D; a += 2) wr(a, W'(16'hA500 ^ (a * 16'h0111)));
    for (int a = 0; a < D; a++) rd(a, (a % 2 == 0) ? "R3" : "R2");
    wr(2, 16'hFFFF);
    wr(2, 16'h0001);
    rd(2, "R10");
  endtask

  task automatic t_clear();
    for (int a = 0; a < D; a++) wr(a, W'(16'h3C00 + a));
    step(1, 0, 0, '0, 0); model_clear();
    for (int a = 0; a < D; a++) rd(a, "R4");
    wr(5, 16'h5A5A);
    rd(5, "R4");
    rd(6, "R4");
  endtask

  task automatic t_clear_with_write();
    step(1, 1, 7, 16'h1234, 0); model_clear();
    rd(7, "R5");
  endtask

  task automatic t_read_first();
    logic [W-1:0] exp;
    wr(3, 16'h1111);
    exp = v[3] ? m[3] : '0;
    step(0, 1, 3, 16'h2222, 1); m[3] = 16'h2222; v[3] = 1'b1;
    chk("R6", rd_data, exp);
    rd(3, "R6");
    exp = v[9] ? m[9] : '0;
    step(0, 1, 9, 16'h3333, 1); m[9] = 16'h3333; v[9] = 1'b1;
    chk("R6", rd_data, exp);
    rd(9, "R6");
  endtask

  task automatic t_hold();
    rd(3, "R7");
    step(0, 0, 9, '0, 0);         chk("R7", rd_data, 16'h2222);
    step(0, 1, 3, 16'h7777, 0);   m[3] = 16'h7777; v[3] = 1'b1;
    chk("R7", rd_data, 16'h2222);
    step(1, 0, 3, '0, 0);         model_clear();
    chk("R7", rd_data, 16'h2222);
  endtask

  task automatic t_clear_rapid();
    wr(4, 16'h4040);
    step(1, 0, 0, '0, 0); step(1, 0, 0, '0, 0); model_clear();
    rd(4, "R8");
    step(1, 0, 0, '0, 0); model_clear();
    wr(4, 16'h0404);
    rd(4, "R8");
  endtask

  task automatic t_read_with_clear();
    wr(11, 16'h4444);
    step(1, 0, 11, '0, 1); model_clear();
    chk("R9", rd_data, 16'h4444);
    rd(11, "R9");
  endtask

  initial begin
    rst = 1; clr = 0; wr_en = 0; rd_en = 0; addr = '0; wr_data = '0;
    model_clear();
    for (int i = 0; i < D; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_write_read();
    t_clear();
    t_clear_with_write();
    t_read_first();
    t_hold();
    t_clear_rapid();
    t_read_with_clear();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(20ns * 100000);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule